// File: doc/BRIEF.md
# Decode-Stage Hazard and Operand Forwarding Unit

This block is the combinational hazard logic for a five-stage, in-order 32-bit pipeline that resolves branches in decode. It looks at the source register numbers of the instruction in decode and at what it needs them for. An operand can feed the ALU, the branch compare, or both. The block also looks at the register-write flags, destination numbers, load flags and result values of the execute and memory stages. From these it decides whether decode must stall and where each operand value comes from.

A mode input selects one of two behaviours. With forwarding off, every dependency is resolved by stalling. With forwarding on, ALU operands take results from execute or memory. Branch operands get their own rules: they always stall on an execute-stage producer, and they can take a memory-to-decode bypass. The block also forms the destination register number of the decode instruction and puts the return address in place for link instructions. When stall is high, the surrounding pipeline holds fetch and decode and sends a bubble with register-write cleared into execute.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage is a producer for an operand only when its write flag is set, its destination is not register 0, the destination equals the operand's register number, and decode uses that operand (ALU use or branch use). Otherwise nothing is stalled or substituted.
- R2: The writeback stage is never compared. With no producer hit, stall, branchStall, both bypass flags and both selects are 0, and the operands equal the register-file values.
- R3: With forwardEn = 0, an ALU-operand hit in execute or memory raises stall. Both selects stay 0, no bypass is raised, and the operands keep their register-file values.
- R4: With forwardEn = 1, an ALU operand hit only by the memory stage takes memWbVal, and its select reads 2 ("from writeback path").
- R5: With forwardEn = 1, an ALU operand hit by a non-load execute stage takes exAluVal, and its select reads 1 ("from memory path"). This wins over a memory-stage hit on the same operand. Select value 0 means no forwarding.
- R6: With forwardEn = 1, an ALU-operand hit on an execute-stage load raises stall, and no forwarding from execute takes place.
- R7: A branch-operand hit in execute raises both stall and branchStall, in either mode.
- R8: Without an execute branch hit, a branch-operand hit in memory raises stall (branchStall stays 0) when forwardEn = 0 or memLoad = 1.
- R9: Otherwise a branch-operand hit in memory substitutes memWbVal, with no stall. The bypass flag of that operand alone (brBypassRs or brBypassRt) is raised.
- R10: decWriteNum is 31 when decLink = 1, else decRd when decRegDst = 1, else decRt.
- R11: For a link instruction the rt operand carries decPc + 8 in place of the register-file value.
- R12: branchStall is never high without stall, and a select never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| forwardEn | input | 1 | 1 = stall plus forward, 0 = stall only |
| decRs | input | 5 | rs register number in decode |
| decRt | input | 5 | rt register number in decode |
| decRd | input | 5 | rd register number in decode |
| aluUseRs | input | 1 | ALU reads rs |
| aluUseRt | input | 1 | ALU reads rt |
| brUseRs | input | 1 | branch compare or jump register reads rs |
| brUseRt | input | 1 | branch compare reads rt |
| decLink | input | 1 | link instruction |
| decRegDst | input | 1 | destination is rd |
| decPc | input | 32 | address of the decode instruction |
| rfRsVal | input | 32 | register-file value for rs |
| rfRtVal | input | 32 | register-file value for rt |
| exWe | input | 1 | execute stage writes a register |
| exDst | input | 5 | execute destination number |
| exLoad | input | 1 | execute instruction is a load |
| exAluVal | input | 32 | execute ALU result |
| memWe | input | 1 | memory stage writes a register |
| memDst | input | 5 | memory destination number |
| memLoad | input | 1 | memory instruction is a load |
| memWbVal | input | 32 | memory stage write-back value |
| stall | output | 1 | hold fetch/decode, bubble into execute |
| branchStall | output | 1 | stall caused by a branch operand in execute |
| fwdSelRs | output | 2 | rs source: 0 none, 1 from memory path, 2 from writeback path |
| fwdSelRt | output | 2 | rt source, same coding |
| brBypassRs | output | 1 | rs taken from memory stage for branch |
| brBypassRt | output | 1 | rt taken from memory stage for branch |
| opRsVal | output | 32 | resolved rs operand |
| opRtVal | output | 32 | resolved rt operand |
| decWriteNum | output | 5 | destination register of decode instruction |

## Verification
The hardest case is the one where execute and memory both target the same register while decode needs it in several ways at once. An example is an operand used by both the ALU and the branch compare, with one stage a load. Each such case sits at a corner of priority, mode and load flag. The stimulus drives the stage descriptors directly, so execute/memory collisions, zero destinations, unused operands and load flags are set up in isolated vectors. Each vector's expected stall, select, bypass and operand values are queued against the mode in force.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Forward select coding: 0 none, 1 from memory path (execute result),
  // 2 from writeback path (memory-stage write-back value).
  typedef enum logic [1:0] {
    FWD_NONE   = 2'd0,
    FWD_EXEC   = 2'd1,
    FWD_MEMSTG = 2'd2
  } fwd_sel_e;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic     stall;
    logic     branchStall;
    fwd_sel_e selRs;
    fwd_sel_e selRt;
    logic     bypRs;
    logic     bypRt;
  } hz_strobes_t;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              forwardEn,
  input  logic [REG_AW-1:0] decRs,
  input  logic [REG_AW-1:0] decRt,
  input  logic              aluUseRs,
  input  logic              aluUseRt,
  input  logic              brUseRs,
  input  logic              brUseRt,
  input  logic              exWe,
  input  logic [REG_AW-1:0] exDst,
  input  logic              exLoad,
  input  logic              memWe,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memLoad,
  output hz_strobes_t       strobes
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic exLive, memLive;
  logic exRsHit, exRtHit, memRsHit, memRtHit;
  logic aluExDep, aluMemDep, brExDep, brMemDep;

  // A stage counts as a producer only if it writes a nonzero register.
  assign exLive   = exWe  && (exDst  != ZERO_REG);
  assign memLive  = memWe && (memDst != ZERO_REG);
  assign exRsHit  = exLive  && (exDst  == decRs);
  assign exRtHit  = exLive  && (exDst  == decRt);
  assign memRsHit = memLive && (memDst == decRs);
  assign memRtHit = memLive && (memDst == decRt);

  assign aluExDep  = (aluUseRs && exRsHit)  || (aluUseRt && exRtHit);
  assign aluMemDep = (aluUseRs && memRsHit) || (aluUseRt && memRtHit);
  assign brExDep   = (brUseRs  && exRsHit)  || (brUseRt  && exRtHit);
  assign brMemDep  = (brUseRs  && memRsHit) || (brUseRt  && memRtHit);

  always_comb begin
    strobes = '0;
    // ALU operands
    if (!forwardEn) begin
      if (aluExDep || aluMemDep) strobes.stall = 1'b1;
    end else begin
      if (aluUseRs && memRsHit) strobes.selRs = FWD_MEMSTG;
      if (aluUseRt && memRtHit) strobes.selRt = FWD_MEMSTG;
      if (aluExDep) begin
        if (exLoad) begin
          strobes.stall = 1'b1;
        end else begin
          if (aluUseRs && exRsHit) strobes.selRs = FWD_EXEC;
          if (aluUseRt && exRtHit) strobes.selRt = FWD_EXEC;
        end
      end
    end
    // Branch operands compared in decode
    if (brExDep) begin
      strobes.stall       = 1'b1;
      strobes.branchStall = 1'b1;
    end else if (!forwardEn || memLoad) begin
      if (brMemDep) strobes.stall = 1'b1;
    end else begin
      strobes.bypRs = brUseRs && memRsHit;
      strobes.bypRt = brUseRt && memRtHit;
    end
  end

  // Assertions guarding the control strobes
  always_comb begin
    p_bstall_needs_stall_r12: assert (!strobes.branchStall || strobes.stall);
    p_sel_legal_r12: assert (strobes.selRs != 2'd3 && strobes.selRt != 2'd3);
    p_stall_only_quiet_r3: assert (forwardEn ||
      (strobes.selRs == FWD_NONE && strobes.selRt == FWD_NONE &&
       !strobes.bypRs && !strobes.bypRt));
    p_no_zero_forward_r1: assert ((strobes.selRs == FWD_NONE && !strobes.bypRs) ||
                                  decRs != ZERO_REG);
    p_exec_branch_stalls_r7: assert (!(brUseRs && exWe && exDst == decRs &&
      decRs != ZERO_REG) || strobes.branchStall);
  end

endmodule

// File: rtl/hazard_datapath.sv
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 5,
  parameter int LINK_REG    = 31,
  parameter int LINK_OFFSET = 8
) (
  input  hz_strobes_t       strobes,
  input  logic [REG_AW-1:0] decRt,
  input  logic [REG_AW-1:0] decRd,
  input  logic              decLink,
  input  logic              decRegDst,
  input  logic [DATA_W-1:0] decPc,
  input  logic [DATA_W-1:0] rfRsVal,
  input  logic [DATA_W-1:0] rfRtVal,
  input  logic [DATA_W-1:0] exAluVal,
  input  logic [DATA_W-1:0] memWbVal,
  output logic [DATA_W-1:0] opRsVal,
  output logic [DATA_W-1:0] opRtVal,
  output logic [REG_AW-1:0] decWriteNum
);

  localparam logic [REG_AW-1:0] LINK_NUM = REG_AW'(LINK_REG);
  localparam logic [DATA_W-1:0] LINK_ADD = DATA_W'(LINK_OFFSET);

  logic [DATA_W-1:0] baseRt;

  assign baseRt = decLink ? (decPc + LINK_ADD) : rfRtVal;

  always_comb begin
    if (decLink)        decWriteNum = LINK_NUM;
    else if (decRegDst) decWriteNum = decRd;
    else                decWriteNum = decRt;
  end

  // Operand muxes: branch bypass, then execute, then memory, then register file.
  always_comb begin
    if (strobes.bypRs)                   opRsVal = memWbVal;
    else if (strobes.selRs == FWD_EXEC)   opRsVal = exAluVal;
    else if (strobes.selRs == FWD_MEMSTG) opRsVal = memWbVal;
    else                                 opRsVal = rfRsVal;
  end

  always_comb begin
    if (strobes.bypRt)                   opRtVal = memWbVal;
    else if (strobes.selRt == FWD_EXEC)   opRtVal = exAluVal;
    else if (strobes.selRt == FWD_MEMSTG) opRtVal = memWbVal;
    else                                 opRtVal = baseRt;
  end

  // Assertions guarding the operand muxes
  always_comb begin
    p_link_dest_r10: assert (!decLink || decWriteNum == LINK_NUM);
    p_link_value_r11: assert (!(decLink && strobes.selRt == FWD_NONE && !strobes.bypRt) ||
                              opRtVal == decPc + LINK_ADD);
    p_exec_value_r5: assert (!(strobes.selRs == FWD_EXEC && !strobes.bypRs) ||
                             opRsVal == exAluVal);
    p_bypass_value_r9: assert (!strobes.bypRt || opRtVal == memWbVal);
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 5,
  parameter int LINK_REG    = 31,
  parameter int LINK_OFFSET = 8
) (
  input  logic              forwardEn,
  input  logic [REG_AW-1:0] decRs,
  input  logic [REG_AW-1:0] decRt,
  input  logic [REG_AW-1:0] decRd,
  input  logic              aluUseRs,
  input  logic              aluUseRt,
  input  logic              brUseRs,
  input  logic              brUseRt,
  input  logic              decLink,
  input  logic              decRegDst,
  input  logic [DATA_W-1:0] decPc,
  input  logic [DATA_W-1:0] rfRsVal,
  input  logic [DATA_W-1:0] rfRtVal,
  input  logic              exWe,
  input  logic [REG_AW-1:0] exDst,
  input  logic              exLoad,
  input  logic [DATA_W-1:0] exAluVal,
  input  logic              memWe,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memLoad,
  input  logic [DATA_W-1:0] memWbVal,
  output logic              stall,
  output logic              branchStall,
  output logic [1:0]        fwdSelRs,
  output logic [1:0]        fwdSelRt,
  output logic              brBypassRs,
  output logic              brBypassRt,
  output logic [DATA_W-1:0] opRsVal,
  output logic [DATA_W-1:0] opRtVal,
  output logic [REG_AW-1:0] decWriteNum
);

  hz_strobes_t strobes;

  hazard_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .forwardEn(forwardEn), .decRs(decRs), .decRt(decRt),
    .aluUseRs(aluUseRs), .aluUseRt(aluUseRt),
    .brUseRs(brUseRs), .brUseRt(brUseRt),
    .exWe(exWe), .exDst(exDst), .exLoad(exLoad),
    .memWe(memWe), .memDst(memDst), .memLoad(memLoad),
    .strobes(strobes)
  );

  hazard_datapath #(
    .DATA_W(DATA_W), .REG_AW(REG_AW),
    .LINK_REG(LINK_REG), .LINK_OFFSET(LINK_OFFSET)
  ) u_dp (
    .strobes(strobes), .decRt(decRt), .decRd(decRd),
    .decLink(decLink), .decRegDst(decRegDst), .decPc(decPc),
    .rfRsVal(rfRsVal), .rfRtVal(rfRtVal),
    .exAluVal(exAluVal), .memWbVal(memWbVal),
    .opRsVal(opRsVal), .opRtVal(opRtVal), .decWriteNum(decWriteNum)
  );

  assign stall       = strobes.stall;
  assign branchStall = strobes.branchStall;
  assign fwdSelRs    = strobes.selRs;
  assign fwdSelRt    = strobes.selRt;
  assign brBypassRs  = strobes.bypRs;
  assign brBypassRt  = strobes.bypRt;

endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;

  localparam logic [31:0] RSV = 32'h1000_0001;
  localparam logic [31:0] RTV = 32'h2000_0002;
  localparam logic [31:0] EXV = 32'hAAAA_0003;
  localparam logic [31:0] MMV = 32'hBBBB_0004;
  localparam logic [31:0] PCV = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  logic forwardEn, aluUseRs, aluUseRt, brUseRs, brUseRt, decLink, decRegDst;
  logic exWe, exLoad, memWe, memLoad;
  logic [4:0] decRs, decRt, decRd, exDst, memDst;
  logic [31:0] decPc, rfRsVal, rfRtVal, exAluVal, memWbVal;
  logic stall, branchStall, brBypassRs, brBypassRt;
  logic [1:0] fwdSelRs, fwdSelRt;
  logic [31:0] opRsVal, opRtVal;
  logic [4:0] decWriteNum;

  hazard_fwd_unit u_dut (.*);

  typedef struct packed {
    logic st; logic bs; logic [1:0] sr; logic [1:0] st2;
    logic br; logic bt; logic [31:0] rv; logic [31:0] tv; logic [4:0] wn;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic clearIn();
    forwardEn = 1'b1; aluUseRs = 0; aluUseRt = 0; brUseRs = 0; brUseRt = 0;
    decLink = 0; decRegDst = 0; exWe = 0; exLoad = 0; memWe = 0; memLoad = 0;
    decRs = 0; decRt = 0; decRd = 0; exDst = 0; memDst = 0;
    decPc = PCV; rfRsVal = RSV; rfRtVal = RTV; exAluVal = EXV; memWbVal = MMV;
  endtask

  task automatic expectOut(string tag, logic st, logic bs, logic [1:0] sr,
                           logic [1:0] st2, logic br, logic bt,
                           logic [31:0] rv, logic [31:0] tv, logic [4:0] wn);
    exp_t e;
    e = '{st, bs, sr, st2, br, bt, rv, tv, wn};
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && expQ.size() > 0) begin
        exp_t e, a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = '{stall, branchStall, fwdSelRs, fwdSelRt, brBypassRs, brBypassRt,
              opRsVal, opRtVal, decWriteNum};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  // Driver
  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    rst = 1'b0;

    @(posedge clk); clearIn();
    expectOut("R2 idle", 0,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); aluUseRs = 1; exWe = 1; exDst = 0; memWe = 1; memDst = 0;
    expectOut("R1 zero dest", 0,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRs = 5; exWe = 1; exDst = 5; memWe = 1; memDst = 5;
    expectOut("R1 operand unused", 0,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRs = 5; aluUseRs = 1; memDst = 5; exDst = 5;
    expectOut("R1 no write flag", 0,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); forwardEn = 0; decRs = 7; aluUseRs = 1; memWe = 1; memDst = 7;
    expectOut("R3 mem stall-only", 1,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); forwardEn = 0; decRt = 9; aluUseRt = 1; exWe = 1; exDst = 9;
    expectOut("R3 exec stall-only", 1,0,0,0,0,0, RSV, RTV, 5'd9);

    @(posedge clk); clearIn(); decRt = 9; aluUseRt = 1; memWe = 1; memDst = 9;
    expectOut("R4 mem forward", 0,0,0,2,0,0, RSV, MMV, 5'd9);

    @(posedge clk); clearIn(); decRs = 4; aluUseRs = 1; exWe = 1; exDst = 4; memWe = 1; memDst = 4;
    expectOut("R5 exec priority", 0,0,1,0,0,0, EXV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRs = 4; decRt = 6; aluUseRs = 1; aluUseRt = 1;
    exWe = 1; exDst = 4; memWe = 1; memDst = 6;
    expectOut("R5 R4 split sources", 0,0,1,2,0,0, EXV, MMV, 5'd6);

    @(posedge clk); clearIn(); decRs = 4; aluUseRs = 1; exWe = 1; exDst = 4; exLoad = 1;
    expectOut("R6 load-use stall", 1,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRt = 3; brUseRt = 1; exWe = 1; exDst = 3;
    expectOut("R7 branch exec fwd mode", 1,1,0,0,0,0, RSV, RTV, 5'd3);

    @(posedge clk); clearIn(); forwardEn = 0; decRs = 3; brUseRs = 1; exWe = 1; exDst = 3;
    expectOut("R7 branch exec stall mode", 1,1,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRs = 3; brUseRs = 1; memWe = 1; memDst = 3; memLoad = 1;
    expectOut("R8 branch mem load", 1,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); forwardEn = 0; decRs = 3; brUseRs = 1; memWe = 1; memDst = 3;
    expectOut("R8 branch mem stall mode", 1,0,0,0,0,0, RSV, RTV, 5'd0);

    @(posedge clk); clearIn(); decRs = 3; decRt = 8; brUseRs = 1; brUseRt = 1; memWe = 1; memDst = 3;
    expectOut("R9 bypass rs", 0,0,0,0,1,0, MMV, RTV, 5'd8);

    @(posedge clk); clearIn(); decRs = 8; decRt = 3; brUseRs = 1; brUseRt = 1; memWe = 1; memDst = 3;
    expectOut("R9 bypass rt", 0,0,0,0,0,1, RSV, MMV, 5'd3);

    @(posedge clk); clearIn(); decLink = 1; decRegDst = 1; decRd = 12; decRt = 2;
    expectOut("R10 R11 link", 0,0,0,0,0,0, RSV, PCV + 32'd8, 5'd31);

    @(posedge clk); clearIn(); decRegDst = 1; decRd = 12; decRt = 2;
    expectOut("R10 rd dest", 0,0,0,0,0,0, RSV, RTV, 5'd12);

    @(posedge clk); clearIn(); decRs = 10; aluUseRs = 1; brUseRs = 1; memWe = 1; memDst = 10;
    expectOut("R12 R9 alu+branch mem", 0,0,2,0,1,0, MMV, RTV, 5'd0);

    @(posedge clk); clearIn();
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule